// File: doc/BRIEF.md
# Single-transfer control bus master with response timeout

This block is the only master on a narrow register-configuration bus. A user-side client hands it one read or write command at a time through a request/ready handshake. The master turns each command into a single transfer. First comes a command stage one clock long, in which the enable, direction and address lines are driven. Then come one or more data cycles on a shared bidirectional data line, which the master drives for writes and releases for reads.

The transfer ends when the addressed slave raises its valid handshake in a data cycle. If no valid arrives within a parameterised number of data cycles, a response timer ends the transfer with an error. The client then decides whether to retry or drop the command. There is no arbitration and no burst support. A transfer that times out leaves the last read data untouched.

Top module: `cbus_master`

## Requirements
- R1: A request is taken only in a cycle where `usr_ready` is 1, which is the idle state. `usr_ready` is 0 from the cycle after acceptance until the completion cycle. The command stage appears in the cycle right after the accepting clock edge.
- R2: The command stage lasts exactly one cycle, with `bus_ce` at 1, `bus_addr` equal to the accepted address and `bus_wr` set to 1 for a write and 0 for a read. `bus_ce` is 0 in every other cycle.
- R3: For a write, `bus_data` carries the accepted write data in every data cycle, even if `usr_wdata` changes after acceptance. In idle cycles, in command cycles and in all cycles of a read, the master leaves `bus_data` undriven (high impedance).
- R4: Outside the command stage, `bus_addr` and `bus_wr` keep the values of the most recent command stage.
- R5: If `bus_vld` is sampled 1 at a clock edge during a data cycle, `usr_done` is 1 for exactly the next cycle with `usr_err` 0. For a read, `usr_rdata` then holds the value that was on `bus_data` at that edge.
- R6: Suppose `bus_vld` stays 0 for TMO_CYC consecutive data cycles. Then `usr_done` and `usr_err` are both 1 in the following cycle, which is TMO_CYC+1 cycles after the command stage, and `usr_rdata` keeps its previous value. A valid seen in data cycle TMO_CYC-1 still completes without error.
- R7: `bus_vld` has no effect in idle cycles or in the command stage.
- R8: While `rst_n` is 0: `usr_ready` is 1; `bus_ce`, `bus_wr`, `bus_addr`, `usr_done`, `usr_err` and `usr_rdata` are 0; `bus_data` is undriven. Asserting reset in the middle of a transfer abandons that transfer.
- R9: In the completion cycle `usr_ready` is already 1, so a request given in that cycle is accepted. Its command stage follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_req | input | 1 | Client command request |
| usr_wr | input | 1 | Client direction, 1 write, 0 read |
| usr_addr | input | AW | Client target address |
| usr_wdata | input | DW | Client write data |
| usr_ready | output | 1 | Master idle, request taken this cycle |
| usr_done | output | 1 | One-cycle completion pulse |
| usr_err | output | 1 | Completion was a response timeout |
| usr_rdata | output | DW | Last successfully read data |
| bus_ce | output | 1 | Command stage enable |
| bus_wr | output | 1 | Bus direction, 1 write, 0 read |
| bus_addr | output | AW | Bus address |
| bus_data | inout | DW | Shared bidirectional data line |
| bus_vld | input | 1 | Slave valid handshake |

## Verification
Two events can share one cycle: the completion pulse of one transfer and the acceptance of the next request. The stimulus table is run back to back, so each new request is raised in the very cycle where `usr_done` is checked. The bench then requires a command stage with the new address in the next cycle, while the completed transfer's error flag and read data are judged in that same shared cycle. A second overlap sits on the timer boundary. Valid is given in the last allowed data cycle in one case and withheld one cycle longer in another, so that the success and timeout outcomes are separated by a single cycle.

// File: rtl/cbus_pkg.sv
package cbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2
  } cbus_state_e;

endpackage

// File: rtl/cbus_rsp_timer.sv
module cbus_rsp_timer #(
  parameter int TMO_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/cbus_data_port.sv
module cbus_data_port #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drv_en,
  input  logic [DW-1:0] drv_data,
  input  logic          cap_en,
  inout  wire  [DW-1:0] pad,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rdata_q, rdata_d;

  assign pad = drv_en ? drv_data : {DW{1'bz}};

  always_comb begin
    rdata_d = rdata_q;
    if (cap_en) rdata_d = pad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/cbus_seq.sv
module cbus_seq
  import cbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usr_req,
  input  logic          usr_wr,
  input  logic [AW-1:0] usr_addr,
  input  logic [DW-1:0] usr_wdata,
  input  logic          bus_vld,
  input  logic          tmo_expired,
  output logic          usr_ready,
  output logic          usr_done,
  output logic          usr_err,
  output logic          bus_ce,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic          drv_en,
  output logic [DW-1:0] drv_data,
  output logic          cap_en,
  output logic          timer_run
);
  cbus_state_e   state_q, state_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          accept;

  assign accept = (state_q == ST_IDLE) && usr_req;

  always_comb begin
    state_d = state_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_CMD;
          wr_d    = usr_wr;
          addr_d  = usr_addr;
          wdata_d = usr_wdata;
        end
      end
      ST_CMD: state_d = ST_DATA;
      ST_DATA: begin
        if (bus_vld) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (tmo_expired) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign usr_ready = (state_q == ST_IDLE);
  assign usr_done  = done_q;
  assign usr_err   = err_q;
  assign bus_ce    = (state_q == ST_CMD);
  assign bus_wr    = wr_q;
  assign bus_addr  = addr_q;
  assign timer_run = (state_q == ST_DATA);
  assign drv_en    = timer_run && wr_q;
  assign drv_data  = wdata_q;
  assign cap_en    = timer_run && !wr_q && bus_vld;

endmodule

// File: rtl/cbus_master.sv
module cbus_master #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int TMO_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usr_req,
  input  logic          usr_wr,
  input  logic [AW-1:0] usr_addr,
  input  logic [DW-1:0] usr_wdata,
  output logic          usr_ready,
  output logic          usr_done,
  output logic          usr_err,
  output logic [DW-1:0] usr_rdata,
  output logic          bus_ce,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  inout  wire  [DW-1:0] bus_data,
  input  logic          bus_vld
);
  logic          tmo_expired;
  logic          timer_run;
  logic          drv_en;
  logic          cap_en;
  logic [DW-1:0] drv_data;

  cbus_seq #(.AW(AW), .DW(DW)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .usr_req    (usr_req),
    .usr_wr     (usr_wr),
    .usr_addr   (usr_addr),
    .usr_wdata  (usr_wdata),
    .bus_vld    (bus_vld),
    .tmo_expired(tmo_expired),
    .usr_ready  (usr_ready),
    .usr_done   (usr_done),
    .usr_err    (usr_err),
    .bus_ce     (bus_ce),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .drv_en     (drv_en),
    .drv_data   (drv_data),
    .cap_en     (cap_en),
    .timer_run  (timer_run)
  );

  cbus_rsp_timer #(.TMO_CYC(TMO_CYC)) tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (timer_run),
    .expired(tmo_expired)
  );

  cbus_data_port #(.DW(DW)) dport_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .drv_en  (drv_en),
    .drv_data(drv_data),
    .cap_en  (cap_en),
    .pad     (bus_data),
    .rdata   (usr_rdata)
  );

endmodule

// File: rtl/cbus_master_chk.sv
module cbus_master_chk #(
  parameter int AW      = 16,
  parameter int TMO_CYC = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          usr_req,
  input logic          usr_ready,
  input logic          usr_done,
  input logic          usr_err,
  input logic          bus_ce,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr
);
  localparam int WC_W = $clog2(TMO_CYC + 3) + 1;

  logic [WC_W-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wait_cnt <= '0;
    else if (bus_ce)           wait_cnt <= WC_W'(1);
    else if (usr_done)         wait_cnt <= '0;
    else if (wait_cnt != '0)   wait_cnt <= wait_cnt + 1'b1;
  end

  AST_ACCEPT_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_req && usr_ready) |=> bus_ce); // R1
  AST_BUSY_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ce |-> !usr_ready); // R1
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ce |=> !bus_ce); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ce |-> $stable(bus_addr)); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ce |-> $stable(bus_wr)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    usr_done |=> !usr_done); // R5
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    usr_err |-> usr_done); // R6
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= WC_W'(TMO_CYC + 1)); // R6
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    usr_done |-> usr_ready); // R9

endmodule

bind cbus_master cbus_master_chk #(.AW(AW), .TMO_CYC(TMO_CYC)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .usr_req  (usr_req),
  .usr_ready(usr_ready),
  .usr_done (usr_done),
  .usr_err  (usr_err),
  .bus_ce   (bus_ce),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr)
);

// File: tb/cbus_master_tb_top.sv
`timescale 1ns/1ps
module cbus_master_tb_top;
  localparam int AW  = 16;
  localparam int DW  = 32;
  localparam int TMO = 16;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [7:0]    lat;
    logic [DW-1:0] sdata;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0010, 32'h1234_5678, 8'd0,  32'h0},
    '{1'b0, 16'h0014, 32'h0,         8'd3,  32'hCAFE_0001},
    '{1'b1, 16'hF000, 32'h0000_00A5, 8'd15, 32'h0},
    '{1'b0, 16'h1FFC, 32'h0,         8'd16, 32'hDEAD_BEEF},
    '{1'b0, 16'h0FF0, 32'h0,         8'd15, 32'h0BAD_F00D},
    '{1'b1, 16'h0004, 32'h8000_0001, 8'd16, 32'h0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          usr_req, usr_wr;
  logic [AW-1:0] usr_addr;
  logic [DW-1:0] usr_wdata;
  logic          usr_ready, usr_done, usr_err;
  logic [DW-1:0] usr_rdata;
  logic          bus_ce, bus_wr;
  logic [AW-1:0] bus_addr;
  tri1  [DW-1:0] bus_w;
  logic          bus_vld;
  logic          s_drv;
  logic [DW-1:0] s_data;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] exp_rd = '0;

  localparam logic [DW-1:0] FLOAT = '1;

  assign bus_w = s_drv ? s_data : {DW{1'bz}};

  always #2.5 clk = ~clk;

  cbus_master #(.AW(AW), .DW(DW), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .usr_req(usr_req), .usr_wr(usr_wr), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
    .usr_ready(usr_ready), .usr_done(usr_done), .usr_err(usr_err), .usr_rdata(usr_rdata),
    .bus_ce(bus_ce), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_data(bus_w),
    .bus_vld(bus_vld)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Call at a negedge with the master idle; returns at the negedge of the completion cycle.
  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input int lat, input logic [DW-1:0] sd);
    chk(usr_ready == 1'b1, "R1 ready before request", 64'(usr_ready), 64'd1);
    usr_req = 1'b1; usr_wr = wr; usr_addr = a; usr_wdata = wd;
    @(negedge clk);
    usr_req = 1'b0; usr_wdata = ~wd; usr_addr = ~a; usr_wr = ~wr;
    chk(bus_ce == 1'b1, "R2 ce in command stage", 64'(bus_ce), 64'd1);
    chk(bus_addr == a, "R2 command address", 64'(bus_addr), 64'(a));
    chk(bus_wr == wr, "R2 command direction", 64'(bus_wr), 64'(wr));
    chk(usr_ready == 1'b0, "R1 busy in command stage", 64'(usr_ready), 64'd0);
    chk(bus_w == FLOAT, "R3 undriven in command stage", 64'(bus_w), 64'(FLOAT));
    for (int k = 0; k < TMO; k++) begin
      @(negedge clk);
      chk(bus_ce == 1'b0, "R2 ce low in data cycle", 64'(bus_ce), 64'd0);
      chk(bus_addr == a, "R4 address held", 64'(bus_addr), 64'(a));
      chk(bus_wr == wr, "R4 direction held", 64'(bus_wr), 64'(wr));
      chk(usr_done == 1'b0, "R6 no early done", 64'(usr_done), 64'd0);
      if (wr) chk(bus_w == wd, "R3 write data driven", 64'(bus_w), 64'(wd));
      else    chk(bus_w == FLOAT, "R3 released on read", 64'(bus_w), 64'(FLOAT));
      if (k == lat) begin
        bus_vld = 1'b1;
        if (!wr) begin s_drv = 1'b1; s_data = sd; end
        break;
      end
    end
    @(negedge clk);
    bus_vld = 1'b0; s_drv = 1'b0;
    if (lat < TMO && !wr) exp_rd = sd;
    chk(usr_done == 1'b1, "R5 R6 done pulse", 64'(usr_done), 64'd1);
    chk(usr_err == (lat >= TMO), "R5 R6 error flag", 64'(usr_err), 64'(lat >= TMO));
    chk(usr_rdata == exp_rd, "R5 R6 read data", 64'(usr_rdata), 64'(exp_rd));
    chk(usr_ready == 1'b1, "R9 ready in done cycle", 64'(usr_ready), 64'd1);
    chk(bus_addr == a, "R4 address held after done", 64'(bus_addr), 64'(a));
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; usr_req = 1'b0; usr_wr = 1'b0; usr_addr = '0; usr_wdata = '0;
    bus_vld = 1'b0; s_drv = 1'b0; s_data = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(usr_ready == 1'b1, "R8 ready in reset", 64'(usr_ready), 64'd1);
    chk(bus_ce == 1'b0, "R8 ce in reset", 64'(bus_ce), 64'd0);
    chk(bus_addr == '0 && bus_wr == 1'b0, "R8 address/direction in reset", 64'(bus_addr), 64'd0);
    chk(usr_done == 1'b0 && usr_err == 1'b0, "R8 done/err in reset", 64'(usr_done), 64'd0);
    chk(usr_rdata == '0, "R8 rdata in reset", 64'(usr_rdata), 64'd0);
    chk(bus_w == FLOAT, "R8 bus undriven in reset", 64'(bus_w), 64'(FLOAT));
    rst_n = 1'b1;
    @(negedge clk);

    // Table, run back to back: each request is raised in the previous done cycle (R9)
    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].wr, VECS[i].addr, VECS[i].wdata, int'(VECS[i].lat), VECS[i].sdata);
      if (i > 0) chk(1'b1, "R9 back-to-back", 64'd0, 64'd0);
    end

    // R5: done is a single pulse, idle gap afterwards
    @(negedge clk);
    chk(usr_done == 1'b0 && usr_err == 1'b0, "R5 done drops after one cycle", 64'(usr_done), 64'd0);
    chk(bus_ce == 1'b0, "R2 no command while idle", 64'(bus_ce), 64'd0);

    // R7: valid while idle is ignored
    bus_vld = 1'b1;
    @(negedge clk);
    bus_vld = 1'b0;
    chk(usr_done == 1'b0 && usr_ready == 1'b1, "R7 idle valid ignored", 64'(usr_done), 64'd0);

    // R7: valid during the command stage is ignored -> transfer times out
    usr_req = 1'b1; usr_wr = 1'b0; usr_addr = 16'h0200;
    @(negedge clk);
    usr_req = 1'b0;
    chk(bus_ce == 1'b1, "R7 command stage reached", 64'(bus_ce), 64'd1);
    bus_vld = 1'b1; s_drv = 1'b1; s_data = 32'h5555_AAAA;
    @(negedge clk);
    bus_vld = 1'b0; s_drv = 1'b0;
    chk(usr_done == 1'b0, "R7 command-stage valid ignored", 64'(usr_done), 64'd0);
    repeat (TMO - 1) @(negedge clk);
    chk(usr_done == 1'b0, "R6 still waiting at last data cycle", 64'(usr_done), 64'd0);
    @(negedge clk);
    chk(usr_done == 1'b1 && usr_err == 1'b1, "R7 R6 timeout after ignored valid", 64'(usr_err), 64'd1);
    chk(usr_rdata == exp_rd, "R7 rdata unchanged", 64'(usr_rdata), 64'(exp_rd));

    // R8: reset in the middle of a transfer abandons it
    @(negedge clk);
    usr_req = 1'b1; usr_wr = 1'b1; usr_addr = 16'h0300; usr_wdata = 32'h0F0F_0F0F;
    @(negedge clk);
    usr_req = 1'b0;
    @(negedge clk);
    chk(bus_w == 32'h0F0F_0F0F, "R3 write driven before reset", 64'(bus_w), 64'h0F0F_0F0F);
    rst_n = 1'b0;
    #1;
    chk(usr_ready == 1'b1 && bus_ce == 1'b0, "R8 mid-transfer reset idles", 64'(usr_ready), 64'd1);
    chk(bus_w == FLOAT && usr_rdata == '0, "R8 bus released on reset", 64'(bus_w), 64'(FLOAT));
    @(negedge clk);
    rst_n = 1'b1;
    exp_rd = '0;
    @(negedge clk);
    xfer(1'b0, 16'h0008, 32'h0, 2, 32'h7654_3210);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule